// File: doc/BRIEF.md
# Sample-Rate Divider and Word Packer

This block turns a fixed base clock into a programmable sample strobe and, on every strobe, records the sixteen channel inputs after gating them with a per-channel enable mask. Consecutive samples are paired into 32-bit words, which are written to a capture memory through a plain address, data and write-enable interface. A word counter ends the capture once a programmed number of words has been stored.

The divider takes the base rate divided by the wanted rate, minus one. A value of zero gives one sample per base clock, and larger values stretch the interval down to the slowest 1/2/5 step. Software arms capture with `arm` and restarts the memory side with `mem_clear`, which returns the write pointer, the half-word phase, the word count and the done flag to their start values. The usual word limit is the memory depth minus five.

Top module: `sample_pack_capture`

## Requirements
- R1: During and directly after reset, `sample_stb`, `mem_we` and `done` are 0 and `mem_addr` and `mem_data` are 0.
- R2: While `arm` is 1 and `done` is 0, `sample_stb` is 1 for one clock out of every `div_count`+1 clocks. The first strobe comes in the (`div_count`+1)-th armed clock. A `div_count` of 0 strobes on every clock.
- R3: Bit i of a recorded sample equals `chan_in[i]` AND `chan_mask[i]`, both taken in the strobe clock.
- R4: Two consecutive recorded samples form one word. The earlier sample goes in bits 31:16 and the later one in bits 15:0. The word appears on `mem_data` with `mem_we` high in the clock after the second strobe.
- R5: `mem_we` is a one-clock pulse and never stays high for two clocks in a row. Exactly one write occurs per two accepted strobes.
- R6: The first write after reset or `mem_clear` goes to address 0. Each later write goes to the previous address plus one.
- R7: `done` rises together with the write that brings the word count up to `word_limit` (valid range 1 to the memory depth). It then stays high, and no strobe or write occurs until `mem_clear`.
- R8: `mem_clear` returns the pointer to 0, the phase to even, the count to 0 and `done` to 0, and restarts the divider. A strobe in the same clock as `mem_clear` records nothing, and `mem_we` is 0 in the next clock.
- R9: While `arm` is 0, no strobe occurs and the divider restarts from zero. A half-filled word is kept, and the next accepted strobe completes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm | input | 1 | Capture enable |
| mem_clear | input | 1 | Memory-side restart |
| div_count | input | 20 | Divider value: base/rate minus one |
| chan_mask | input | 16 | Per-channel record enable |
| word_limit | input | 19 | Number of words to capture |
| chan_in | input | 16 | Channel inputs |
| sample_stb | output | 1 | Sample strobe |
| mem_we | output | 1 | Capture memory write enable |
| mem_addr | output | 18 | Capture memory write address |
| mem_data | output | 32 | Packed word for the capture memory |
| done | output | 1 | Word limit reached |

## Verification
A restart can land in the same clock as the strobe that would complete a word. The bench provokes this with the divider at zero: it raises `mem_clear` in the clock where the odd half arrives. It then expects no write in the following clock, and expects the next word to be built from the two samples after the restart and stored at address 0. The last word before the limit also coincides with `done` rising. That case is judged by requiring the write and the flag in the same clock and no strobes afterwards.

// File: rtl/capk_pkg.sv
package capk_pkg;
   typedef enum logic {
      PH_EVEN = 1'b0,
      PH_ODD  = 1'b1
   } half_phase_e;

   function automatic int unsigned addr_bits(input int unsigned depth);
      return (depth > 1) ? $clog2(depth) : 1;
   endfunction
endpackage

// File: rtl/rate_divider.sv
module rate_divider #(
   parameter int DIV_W = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             restart,
   input  logic [DIV_W-1:0] div,
   output logic             stb
);
   logic [DIV_W-1:0] cnt_q;

   assign stb = run && (cnt_q >= div);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cnt_q <= '0;
      else if (restart || !run)   cnt_q <= '0;
      else if (cnt_q >= div)      cnt_q <= '0;
      else                        cnt_q <= cnt_q + 1'b1;
   end

   // R2
   stb_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stb && div != '0 && !restart) |=> (!stb || div == '0));
endmodule

// File: rtl/lane_packer.sv
module lane_packer
   import capk_pkg::*;
#(
   parameter int NUM_CH     = 16,
   parameter bit EARLY_HIGH = 1'b1,
   localparam int WORD_W    = 2 * NUM_CH
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              stb,
   input  logic [NUM_CH-1:0] chan_in,
   input  logic [NUM_CH-1:0] chan_mask,
   output logic              push,
   output logic [WORD_W-1:0] push_word
);
   logic [NUM_CH-1:0] smp;
   logic [NUM_CH-1:0] hold_q;
   half_phase_e       phase_q;

   for (genvar i = 0; i < NUM_CH; i++) begin : g_gate
      assign smp[i] = chan_in[i] & chan_mask[i];
   end

   if (EARLY_HIGH) begin : g_early_high
      assign push_word = {hold_q, smp};
   end else begin : g_early_low
      assign push_word = {smp, hold_q};
   end

   assign push = stb && !clr && (phase_q == PH_ODD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_EVEN;
         hold_q  <= '0;
      end else if (clr) begin
         phase_q <= PH_EVEN;
      end else if (stb) begin
         if (phase_q == PH_EVEN) begin
            hold_q  <= smp;
            phase_q <= PH_ODD;
         end else begin
            phase_q <= PH_EVEN;
         end
      end
   end

   // R3
   hold_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stb && !clr && phase_q == PH_EVEN) |=> ((hold_q & ~$past(chan_mask)) == '0));
endmodule

// File: rtl/word_store.sv
module word_store #(
   parameter int ADDR_W = 18,
   parameter int WORD_W = 32,
   localparam int CNT_W = ADDR_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              push,
   input  logic [WORD_W-1:0] push_word,
   input  logic [CNT_W-1:0]  limit,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [WORD_W-1:0] mem_data,
   output logic              done
);
   logic [ADDR_W-1:0] ptr_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [CNT_W-1:0]  cnt_nx;

   assign cnt_nx = cnt_q + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q    <= '0;
         cnt_q    <= '0;
         done     <= 1'b0;
         mem_we   <= 1'b0;
         mem_addr <= '0;
         mem_data <= '0;
      end else if (clr) begin
         ptr_q  <= '0;
         cnt_q  <= '0;
         done   <= 1'b0;
         mem_we <= 1'b0;
      end else begin
         mem_we <= push;
         if (push) begin
            mem_addr <= ptr_q;
            mem_data <= push_word;
            ptr_q    <= ptr_q + 1'b1;
            cnt_q    <= cnt_nx;
            if (cnt_nx == limit) done <= 1'b1;
         end
      end
   end

   // R5
   we_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> !mem_we);
endmodule

// File: rtl/sample_pack_capture.sv
module sample_pack_capture #(
   parameter int NUM_CH     = 16,
   parameter int DEPTH      = 262144,
   parameter int DIV_W      = 20,
   parameter bit EARLY_HIGH = 1'b1,
   localparam int WORD_W    = 2 * NUM_CH,
   localparam int ADDR_W    = capk_pkg::addr_bits(DEPTH),
   localparam int CNT_W     = ADDR_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              arm,
   input  logic              mem_clear,
   input  logic [DIV_W-1:0]  div_count,
   input  logic [NUM_CH-1:0] chan_mask,
   input  logic [CNT_W-1:0]  word_limit,
   input  logic [NUM_CH-1:0] chan_in,
   output logic              sample_stb,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [WORD_W-1:0] mem_data,
   output logic              done
);
   if (NUM_CH < 1) begin : g_bad_ch
      $error("NUM_CH must be at least 1");
   end
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if (DIV_W < 1) begin : g_bad_div
      $error("DIV_W must be at least 1");
   end

   logic              run;
   logic              push;
   logic [WORD_W-1:0] push_word;

   assign run = arm && !done;

   rate_divider #(.DIV_W(DIV_W)) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run),
      .restart (mem_clear),
      .div     (div_count),
      .stb     (sample_stb)
   );

   lane_packer #(.NUM_CH(NUM_CH), .EARLY_HIGH(EARLY_HIGH)) u_pack (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (mem_clear),
      .stb       (sample_stb),
      .chan_in   (chan_in),
      .chan_mask (chan_mask),
      .push      (push),
      .push_word (push_word)
   );

   word_store #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (mem_clear),
      .push      (push),
      .push_word (push_word),
      .limit     (word_limit),
      .mem_we    (mem_we),
      .mem_addr  (mem_addr),
      .mem_data  (mem_data),
      .done      (done)
   );

   // R7
   done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !sample_stb);

   // R7
   done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !mem_clear) |=> done);

   // R8
   clear_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_clear |=> (!mem_we && !done));
endmodule

// File: tb/sample_pack_capture_tb_top.sv
module sample_pack_capture_tb_top;
   localparam int NCH = 16;
   localparam int DW  = 20;
   localparam int AW  = 18;
   localparam int DEP = 262144;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic arm = 1'b0;
   logic mem_clear = 1'b0;
   logic [DW-1:0]  div_count = '0;
   logic [NCH-1:0] chan_mask = '1;
   logic [AW:0]    word_limit = 19'd100;
   logic [NCH-1:0] chan_in = '0;
   logic           sample_stb, mem_we, done;
   logic [AW-1:0]  mem_addr;
   logic [31:0]    mem_data;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   sample_pack_capture dut_i (
      .clk(clk), .rst_n(rst_n), .arm(arm), .mem_clear(mem_clear),
      .div_count(div_count), .chan_mask(chan_mask), .word_limit(word_limit),
      .chan_in(chan_in), .sample_stb(sample_stb), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_data(mem_data), .done(done));

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
      end
   endtask

   // behavioural reference
   int          m_cnt = 0;
   bit          m_odd = 0;
   logic [15:0] m_hold = '0;
   int          m_ptr = 0;
   int          m_words = 0;
   bit          m_done = 0;
   bit          m_we = 0;
   int          m_addr = 0;
   logic [31:0] m_data = '0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 0; m_odd = 0; m_hold = '0; m_ptr = 0; m_words = 0;
         m_done = 0; m_we = 0; m_addr = 0; m_data = '0;
      end else begin
         bit run, stb;
         logic [15:0] s;
         run = arm && !m_done;
         stb = run && (m_cnt >= int'(div_count));
         s = chan_in & chan_mask;
         if (mem_clear) begin
            m_cnt = 0; m_odd = 0; m_ptr = 0; m_words = 0; m_done = 0; m_we = 0;
         end else begin
            m_we = 0;
            if (!run || stb) m_cnt = 0; else m_cnt++;
            if (stb) begin
               if (!m_odd) begin
                  m_hold = s; m_odd = 1;
               end else begin
                  m_data = {m_hold, s};
                  m_addr = m_ptr;
                  m_we = 1;
                  m_ptr = (m_ptr + 1) % DEP;
                  m_words++;
                  if (m_words == int'(word_limit)) m_done = 1;
                  m_odd = 0;
               end
            end
         end
      end
   end

   logic [31:0] wq[$];
   int          aq[$];
   int          stb_seen = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         bit e_stb;
         e_stb = arm && !m_done && (m_cnt >= int'(div_count));
         check("R2 stb", {31'b0, sample_stb}, {31'b0, e_stb});
         check("R5 we", {31'b0, mem_we}, {31'b0, m_we});
         check("R7 done", {31'b0, done}, {31'b0, m_done});
         if (m_we) begin
            check("R4 data", mem_data, m_data);
            check("R6 addr", {14'b0, mem_addr}, m_addr);
         end
         if (mem_we) begin
            wq.push_back(mem_data);
            aq.push_back(int'(mem_addr));
         end
         if (sample_stb) stb_seen++;
      end
   end

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic restart_mem();
      mem_clear = 1'b1;
      tick(1);
      mem_clear = 1'b0;
      wq.delete();
      aq.delete();
      stb_seen = 0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      tick(3);
      @(negedge clk);
      // R1 reset state
      check("R1 stb", {31'b0, sample_stb}, 0);
      check("R1 we", {31'b0, mem_we}, 0);
      check("R1 done", {31'b0, done}, 0);
      check("R1 addr", {14'b0, mem_addr}, 0);
      check("R1 data", mem_data, 0);
      @(posedge clk); #2;
      rst_n = 1'b1;
      tick(2);

      // R4 packing order, full rate
      restart_mem();
      div_count = 0; chan_mask = 16'hFFFF;
      arm = 1; chan_in = 16'h1111; tick(1);
      chan_in = 16'h2222; tick(1);
      arm = 0; tick(3);
      check("R4 count", wq.size(), 1);
      if (wq.size() > 0) check("R4 word", wq[0], 32'h11112222);

      // R3 channel mask
      restart_mem();
      chan_mask = 16'hA5A5; chan_in = 16'hFFFF; arm = 1; tick(6);
      arm = 0; tick(3);
      check("R3 count", wq.size(), 3);
      foreach (wq[i]) check("R3 word", wq[i], 32'hA5A5A5A5);
      chan_mask = 16'hFFFF;

      // R2 strobe spacing, div=3 over 40 armed clocks
      restart_mem();
      div_count = 3; arm = 1;
      for (int k = 0; k < 40; k++) begin
         chan_in = 16'(k * 16'h0101); tick(1);
      end
      arm = 0; tick(2);
      check("R2 strobes", stb_seen, 10);
      check("R5 writes", wq.size(), 5);

      // R6, R7 word limit
      restart_mem();
      div_count = 1; word_limit = 3; arm = 1;
      for (int k = 0; k < 30; k++) begin
         chan_in = 16'(16'h1000 + k); tick(1);
      end
      check("R7 words", wq.size(), 3);
      check("R7 done held", {31'b0, done}, 1);
      check("R7 strobes", stb_seen, 6);
      foreach (aq[i]) check("R6 addr seq", aq[i], i);
      arm = 0; word_limit = 100;

      // R9 pause keeps half word
      restart_mem();
      check("R8 done clr", {31'b0, done}, 0);
      div_count = 0; arm = 1; chan_in = 16'h0A0A; tick(1);
      arm = 0; chan_in = 16'hFFFF; tick(5);
      arm = 1; chan_in = 16'h0B0B; tick(1);
      arm = 0; tick(3);
      check("R9 count", wq.size(), 1);
      if (wq.size() > 0) check("R9 word", wq[0], 32'h0A0A0B0B);

      // R8 clear colliding with completing strobe
      restart_mem();
      arm = 1; chan_in = 16'h1234; tick(1);
      mem_clear = 1; chan_in = 16'h5678; tick(1);
      mem_clear = 0; chan_in = 16'h9ABC; tick(1);
      chan_in = 16'hDEF0; tick(1);
      arm = 0; tick(3);
      check("R8 count", wq.size(), 1);
      if (wq.size() > 0) begin
         check("R8 word", wq[0], 32'h9ABCDEF0);
         check("R8 addr", aq[0], 0);
      end

      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule